// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block collects hardware error indications into a 64-bit sticky fault register and sorts each position into an attention class. Every cycle the error input vector is ORed into the fault register, and a set bit stays set until software clears it. A mask register suppresses chosen positions. Two action registers give each position a two-bit class code. Code 00 (both action bits clear) makes an unmasked fault a check-stop fault. Code 01 (action 0 clear, action 1 set) makes it a recoverable fault. Codes 10 and 11 raise no attention from this block.

Software reaches the registers over a synchronous bus with an address, write data, a write enable and read data. Each word offset has a fixed role. Alias offsets give a single-cycle AND-clear or OR-set on the fault register and on the mask, so no read-modify-write sequence is needed. Each class drives one registered attention output, which is the OR of all positions that fall in that class.

Top module: `fir_bank`

## Requirements
- R1: After reset the fault register reads all zeros, the mask reads all ones, both action registers read all zeros, and both attention outputs are low.
- R2: Offset 0 reads the fault register. Each cycle the error input vector is ORed into it, and a set bit stays set until it is cleared.
- R3: A write to offset 1 ANDs its data into the fault register. A write to offset 2 ORs its data into the fault register.
- R4: When an error input bit and an AND-clear hit the same position in the same cycle, that position ends up set.
- R5: Offset 3 reads the mask and a write there replaces it. A write to offset 4 ANDs its data into the mask. A write to offset 5 ORs its data into the mask.
- R6: Offsets 6 and 7 read and write action register 0 and action register 1 as whole 64-bit words.
- R7: The check-stop output is the OR over all positions of fault & ~mask & ~act0 & ~act1.
- R8: The recoverable output is the OR over all positions of fault & ~mask & ~act0 & act1.
- R9: A position whose mask bit is set raises neither output, even when its fault bit is set.
- R10: Both attention outputs are registered and reflect the register state one clock after an update.
- R11: Reads of offsets 1, 2, 4, 5 and of unmapped offsets return zero. Writes to unmapped offsets change no register.
- R12: Read data is combinational from the current address and register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word offset from the block base |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 64 | Read data |
| err_in | input | 64 | Hardware error pulses, one per position |
| att_chkstop | output | 1 | Check-stop attention |
| att_recov | output | 1 | Recoverable attention |

## Verification
The hardest case to reach is an error pulse that lands in the same cycle as an AND-clear of the same bit. Directed steps line up both on one clock edge, and the random phase keeps hitting the case by driving clears and sparse error vectors together. The attention classes also need faults that are unmasked and carry each action code. The random phase therefore builds sparse masks and action words, so every code shows up on live fault bits. A bench model predicts every register and both outputs, taking the one-clock output latency into account.

// File: rtl/fir_bank.sv
module fir_bank #(
  parameter int W      = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_we,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      err_in,
  output logic              att_chkstop,
  output logic              att_recov
);

  localparam logic [ADDR_W-1:0] OFS_FLT    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_FLT_AN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_FLT_OR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_MSK    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_MSK_AN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_MSK_OR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFS_ACT0   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_ACT1   = ADDR_W'(7);

  logic [W-1:0] flt_q, msk_q, act0_q, act1_q;
  logic [W-1:0] flt_d, msk_d, act0_d, act1_d;
  logic [W-1:0] cs_vec, rc_vec;

  always_comb begin
    flt_d  = flt_q;
    msk_d  = msk_q;
    act0_d = act0_q;
    act1_d = act1_q;
    if (bus_we) begin
      case (bus_addr)
        OFS_FLT_AN: flt_d  = flt_q & bus_wdata;
        OFS_FLT_OR: flt_d  = flt_q | bus_wdata;
        OFS_MSK:    msk_d  = bus_wdata;
        OFS_MSK_AN: msk_d  = msk_q & bus_wdata;
        OFS_MSK_OR: msk_d  = msk_q | bus_wdata;
        OFS_ACT0:   act0_d = bus_wdata;
        OFS_ACT1:   act1_d = bus_wdata;
        default: ;
      endcase
    end
    flt_d = flt_d | err_in;
  end

  assign cs_vec = flt_q & ~msk_q & ~act0_q & ~act1_q;
  assign rc_vec = flt_q & ~msk_q & ~act0_q &  act1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_q       <= '0;
      msk_q       <= '1;
      act0_q      <= '0;
      act1_q      <= '0;
      att_chkstop <= 1'b0;
      att_recov   <= 1'b0;
    end else begin
      flt_q       <= flt_d;
      msk_q       <= msk_d;
      act0_q      <= act0_d;
      act1_q      <= act1_d;
      att_chkstop <= |cs_vec;
      att_recov   <= |rc_vec;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_FLT:  bus_rdata = flt_q;
      OFS_MSK:  bus_rdata = msk_q;
      OFS_ACT0: bus_rdata = act0_q;
      OFS_ACT1: bus_rdata = act1_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != '0) |=> ((flt_q & $past(err_in)) == $past(err_in))) else $error("sticky"); // R4
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && err_in == '0) |=> $stable(flt_q) && $stable(msk_q)) else $error("hold"); // R2
  AST_MASK_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '1) |=> !att_chkstop && !att_recov) else $error("mask"); // R9
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(att_chkstop && att_recov && (act1_q == '1) && $stable(act1_q))) else $error("excl"); // R8
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_FLT_AN || bus_addr == OFS_MSK_OR) |-> bus_rdata == '0) else $error("rd0"); // R11

endmodule

// File: tb/fir_bank_tb_top.sv
module fir_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic [63:0] bus_wdata = 0, err_in = 0, bus_rdata;
  logic bus_we = 0, att_chkstop, att_recov;
  int checks = 0, fails = 0;
  logic [63:0] m_flt, m_msk, m_a0, m_a1;
  logic e_cs, e_rc;

  always #4 clk = ~clk;

  fir_bank dut_i (.clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
                  .err_in, .att_chkstop, .att_recov);

  function automatic logic [63:0] rd_model(input logic [3:0] a);
    case (a)
      0: return m_flt; 3: return m_msk; 6: return m_a0; 7: return m_a1;
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [63:0] d, input logic [63:0] e);
    logic [63:0] f;
    bus_we = we; bus_addr = a; bus_wdata = d; err_in = e;
    @(posedge clk);
    e_cs = |(m_flt & ~m_msk & ~m_a0 & ~m_a1);
    e_rc = |(m_flt & ~m_msk & ~m_a0 & m_a1);
    f = m_flt;
    if (we) case (a)
      1: f = m_flt & d; 2: f = m_flt | d;
      3: m_msk = d; 4: m_msk = m_msk & d; 5: m_msk = m_msk | d;
      6: m_a0 = d; 7: m_a1 = d; default: ;
    endcase
    m_flt = f | e;
    #1; bus_we = 0; err_in = 0;
  endtask

  task automatic rd(input string r, input logic [3:0] a);
    bus_addr = a; #1;
    chk(r, bus_rdata, rd_model(a));
  endtask

  task automatic att(input string r);
    chk({r, " chkstop"}, {63'd0, att_chkstop}, {63'd0, e_cs});
    chk({r, " recov"}, {63'd0, att_recov}, {63'd0, e_rc});
  endtask

  initial begin
    fork begin
      repeat (150000) @(posedge clk);
      fails++; $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails); $finish;
    end join_none
    void'($urandom(32'd1234));
    m_flt = 0; m_msk = '1; m_a0 = 0; m_a1 = 0; e_cs = 0; e_rc = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    rd("R1 fault", 0); rd("R1 mask", 3); rd("R1 act0", 6); rd("R1 act1", 7);
    att("R1");
    // R9: masked fault raises nothing
    step(0, 0, 0, 64'h10); step(0, 0, 0, 0); att("R9"); rd("R2 sticky", 0);
    // R5 mask clear via AND alias -> R7 checkstop
    step(1, 4, ~64'h10, 0); rd("R5 and", 3); step(0, 0, 0, 0); att("R7");
    // R8 recoverable
    step(1, 7, 64'h10, 0); step(0, 0, 0, 0); att("R8"); rd("R6 act1", 7);
    step(1, 6, 64'h10, 0); step(0, 0, 0, 0); att("R6 act0 silences");
    // R4 simultaneous clear and set
    step(1, 1, 64'h0, 64'h4); rd("R4", 0);
    step(1, 2, 64'hF000, 0); rd("R3 or", 0);
    step(1, 1, ~64'h4, 0); rd("R3 and", 0);
    step(1, 5, 64'h10, 0); rd("R5 or", 3);
    step(1, 3, 64'h1234, 0); rd("R5 write", 3);
    step(1, 9, 64'hFFFF, 0); rd("R11 unmapped", 9); rd("R11 wo", 1); rd("R11 wo2", 5);
    rd("R11 mask kept", 3); rd("R12 fault", 0);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a; logic [63:0] d, e;
      a = 4'($urandom_range(0, 9));
      d = {$urandom, $urandom};
      if ($urandom_range(0, 1)) d = d & {$urandom, $urandom} & {$urandom, $urandom};
      if (a == 1 || a == 4) d = ~d;
      e = ($urandom_range(0, 3) == 0) ? (64'd1 << $urandom_range(0, 63)) : 64'd0;
      step(1'($urandom_range(0, 1)), a, d, e);
      att("R10 random");
      rd("R12 random", 4'($urandom_range(0, 9)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule